// File: doc/BRIEF.md
# I/O Bus Cycle Sequencer

This block is a clocked bus master that produces a single processor-style I/O machine cycle whenever it is asked to. A client pulses a start request together with a direction bit, an 8-bit port number and, for an output transfer, a data byte. The sequencer then walks through the T-states T1, T2, one automatic wait state, any wait states an external device requests, and T3. Each clock is one T-state. During these states it drives the low address bus, the active-low I/O request strobe and the active-low read or write strobe, and it drives the data bus when writing.

For an input transfer, the byte on the data bus is captured on the clock edge that closes T3. It is returned on a result port together with a one-clock completion pulse. A busy flag covers the whole cycle. Requests that arrive while a cycle is running are dropped. A request that arrives in the completion cycle starts the next transfer immediately.

The number of wait states inserted without condition is a parameter, with a default of one. The state register can be built either one-hot or binary.

Top module: `iocyc_seq`

## Requirements
- R1: While reset is held and after it is released: busy and done are 0, all three strobes are 1, the address bus is 0, the data-bus enable is 0, the data output is 0 and the read result is 0.
- R2: A start request seen at a clock edge while idle makes busy go high from that edge on. Busy stays high through T1, T2, every wait state and T3, and then falls.
- R3: The port number latched at the accepting edge is driven on the address bus from T1 through T3. The address bus is 0 whenever the block is idle.
- R4: The I/O request strobe goes low together with the read strobe (direction 0) or the write strobe (direction 1), from T2 through T3. Otherwise all three are high, and the read and write strobes are never low together.
- R5: Exactly one wait state always follows T2, whatever the wait input does. With the wait input high, the strobes stay low for exactly 3 clocks and busy lasts 4 clocks.
- R6: The active-low wait input is sampled only at the clock edge that ends a wait state. A 0 there adds one more wait state. Its value during T1, T2 and T3 has no effect.
- R7: For a read, the data-bus input present at the edge ending T3 appears on the read result from the done cycle on. It is held until the next read completes, and a write leaves it unchanged.
- R8: For a write, the data-bus enable is 1 and the latched data byte is driven from T1 through T3. At all other times, and during reads, the enable is 0 and the data output is 0.
- R9: Done is high for exactly the one clock after T3, the same clock in which the strobes return high.
- R10: A start request during a running cycle is ignored, and the latched port, data and direction do not change. A start request during the done clock is accepted, so T1 follows directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start pulse for one I/O cycle |
| req_write | input | 1 | Direction: 1 write, 0 read |
| req_port | input | ADDR_W | Port number for the cycle |
| req_wdata | input | DATA_W | Byte to write |
| bus_wait_n | input | 1 | Active-low wait request from the device |
| bus_din | input | DATA_W | Data bus as seen by the master |
| bus_addr | output | ADDR_W | Low address bus |
| bus_iorq_n | output | 1 | Active-low I/O request strobe |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dout | output | DATA_W | Data driven onto the bus |
| bus_doe | output | 1 | Data-bus drive enable |
| rsp_rdata | output | DATA_W | Byte captured by the last read |
| rsp_done | output | 1 | One-clock completion pulse |
| busy | output | 1 | A cycle is in progress |

## Verification
The completion pulse of one transfer and the acceptance of the next request can fall in the same clock. The bench provokes this by raising start exactly in the done cycle of a read and following it with a write. It then judges that T1 with the new port comes on the very next clock, and that the read result from the earlier transfer stays put through the write. A second collision is a wait request that coincides with the automatic wait state. The bench holds the wait input low across T1, T2 and T3 as well as in chosen wait states, and compares the strobe length and every output each clock against a behavioural model.

// File: rtl/iocyc_pkg.sv
package iocyc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_TW   = 3'd3,
      ST_T3   = 3'd4
   } tstate_e;

   localparam int unsigned NUM_ST = 5;

   typedef struct packed {
      logic idle;
      logic t1;
      logic t2;
      logic tw;
      logic t3;
   } phase_t;

endpackage

// File: rtl/iocyc_fsm.sv
module iocyc_fsm
   import iocyc_pkg::*;
#(
   parameter int unsigned AUTO_WAITS = 1,
   parameter bit          ONEHOT     = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   wait_n,
   output phase_t ph,
   output logic   launch
);

   localparam int unsigned CW = (AUTO_WAITS > 1) ? $clog2(AUTO_WAITS) : 1;

   logic [CW-1:0] auto_q, auto_d;
   tstate_e       cur, nxt;

   always_comb begin
      nxt    = cur;
      auto_d = auto_q;
      launch = 1'b0;
      case (cur)
         ST_IDLE: if (start) begin
            nxt    = ST_T1;
            launch = 1'b1;
         end
         ST_T1:   nxt = ST_T2;
         ST_T2: begin
            nxt    = ST_TW;
            auto_d = CW'(AUTO_WAITS - 1);
         end
         ST_TW: begin
            if (auto_q != '0)  auto_d = auto_q - CW'(1);
            else if (wait_n)   nxt    = ST_T3;
         end
         ST_T3:   nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) auto_q <= '0;
      else        auto_q <= auto_d;
   end

   if (ONEHOT) begin : g_onehot
      logic [NUM_ST-1:0] oh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) oh_q <= NUM_ST'(1);
         else        oh_q <= NUM_ST'(1) << nxt;
      end
      always_comb begin
         cur = ST_IDLE;
         if (oh_q[ST_T1]) cur = ST_T1;
         if (oh_q[ST_T2]) cur = ST_T2;
         if (oh_q[ST_TW]) cur = ST_TW;
         if (oh_q[ST_T3]) cur = ST_T3;
      end
      assign ph.idle = oh_q[ST_IDLE];
      assign ph.t1   = oh_q[ST_T1];
      assign ph.t2   = oh_q[ST_T2];
      assign ph.tw   = oh_q[ST_TW];
      assign ph.t3   = oh_q[ST_T3];
   end else begin : g_binary
      tstate_e st_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q <= ST_IDLE;
         else        st_q <= nxt;
      end
      assign cur     = st_q;
      assign ph.idle = (st_q == ST_IDLE);
      assign ph.t1   = (st_q == ST_T1);
      assign ph.t2   = (st_q == ST_T2);
      assign ph.tw   = (st_q == ST_TW);
      assign ph.t3   = (st_q == ST_T3);
   end

endmodule

// File: rtl/iocyc_bus.sv
module iocyc_bus
   import iocyc_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [ADDR_W-1:0] port_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic              write_in,
   input  phase_t            ph,
   output logic [ADDR_W-1:0] addr,
   output logic              iorq_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic [DATA_W-1:0] dout,
   output logic              doe,
   output logic              is_write
);

   logic [ADDR_W-1:0] port_q;
   logic [DATA_W-1:0] data_q;
   logic              dir_q;
   logic              active, strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_q <= '0;
         data_q <= '0;
         dir_q  <= 1'b0;
      end else if (launch) begin
         port_q <= port_in;
         data_q <= wdata_in;
         dir_q  <= write_in;
      end
   end

   assign active   = ph.t1 | ph.t2 | ph.tw | ph.t3;
   assign strobe   = ph.t2 | ph.tw | ph.t3;
   assign addr     = active ? port_q : '0;
   assign iorq_n   = ~strobe;
   assign rd_n     = ~(strobe & ~dir_q);
   assign wr_n     = ~(strobe &  dir_q);
   assign doe      = active & dir_q;
   assign dout     = doe ? data_q : '0;
   assign is_write = dir_q;

endmodule

// File: rtl/iocyc_capture.sv
module iocyc_capture #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              last,
   input  logic              is_write,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] rdata,
   output logic              done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         done  <= 1'b0;
      end else begin
         done <= last;
         if (last && !is_write) rdata <= din;
      end
   end

endmodule

// File: rtl/iocyc_seq.sv
module iocyc_seq
   import iocyc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned AUTO_WAITS = 1,
   parameter bit          ONEHOT     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_port,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              bus_wait_n,
   input  logic [DATA_W-1:0] bus_din,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_iorq_n,
   output logic              bus_rd_n,
   output logic              bus_wr_n,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done,
   output logic              busy
);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("iocyc_seq: ADDR_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("iocyc_seq: DATA_W must be at least 1");
   end
   if (AUTO_WAITS < 1) begin : g_bad_waits
      $error("iocyc_seq: AUTO_WAITS must be at least 1");
   end

   phase_t ph;
   logic   launch;
   logic   is_write;

   iocyc_fsm #(
      .AUTO_WAITS (AUTO_WAITS),
      .ONEHOT     (ONEHOT)
   ) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (req_start),
      .wait_n (bus_wait_n),
      .ph     (ph),
      .launch (launch)
   );

   iocyc_bus #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .port_in  (req_port),
      .wdata_in (req_wdata),
      .write_in (req_write),
      .ph       (ph),
      .addr     (bus_addr),
      .iorq_n   (bus_iorq_n),
      .rd_n     (bus_rd_n),
      .wr_n     (bus_wr_n),
      .dout     (bus_dout),
      .doe      (bus_doe),
      .is_write (is_write)
   );

   iocyc_capture #(
      .DATA_W (DATA_W)
   ) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .last     (ph.t3),
      .is_write (is_write),
      .din      (bus_din),
      .rdata    (rsp_rdata),
      .done     (rsp_done)
   );

   assign busy = ~ph.idle;

endmodule

// File: rtl/iocyc_seq_chk.sv
module iocyc_seq_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_iorq_n,
   input logic              bus_rd_n,
   input logic              bus_wr_n,
   input logic              bus_doe,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              rsp_done,
   input logic              busy
);

   // R4
   strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (bus_iorq_n && bus_rd_n && bus_wr_n));

   // R4
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_rd_n && !bus_wr_n));

   // R2
   t1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (bus_iorq_n && bus_rd_n && bus_wr_n));

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(bus_addr));

   // R5
   auto_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_iorq_n) |=> !bus_iorq_n ##1 !bus_iorq_n);

   // R8
   write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> bus_doe);

   // R8
   read_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> !bus_doe);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R9
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_iorq_n) |-> rsp_done);

   // R7
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rsp_rdata) |-> rsp_done);

endmodule

bind iocyc_seq iocyc_seq_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_iorq_n (bus_iorq_n),
   .bus_rd_n   (bus_rd_n),
   .bus_wr_n   (bus_wr_n),
   .bus_doe    (bus_doe),
   .rsp_rdata  (rsp_rdata),
   .rsp_done   (rsp_done),
   .busy       (busy)
);

// File: tb/iocyc_seq_test.sv
module iocyc_seq_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_start = 1'b0;
   logic       req_write = 1'b0;
   logic [7:0] req_port = 8'h00;
   logic [7:0] req_wdata = 8'h00;
   logic       bus_wait_n = 1'b1;
   logic [7:0] bus_din = 8'h00;
   logic [7:0] bus_addr;
   logic       bus_iorq_n, bus_rd_n, bus_wr_n;
   logic [7:0] bus_dout;
   logic       bus_doe;
   logic [7:0] rsp_rdata;
   logic       rsp_done;
   logic       busy;

   int tests = 0;
   int fails = 0;
   int low_run = 0;
   int last_low = 0;
   bit running = 1'b0;

   always #5 clk = ~clk;

   iocyc_seq uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_start  (req_start),
      .req_write  (req_write),
      .req_port   (req_port),
      .req_wdata  (req_wdata),
      .bus_wait_n (bus_wait_n),
      .bus_din    (bus_din),
      .bus_addr   (bus_addr),
      .bus_iorq_n (bus_iorq_n),
      .bus_rd_n   (bus_rd_n),
      .bus_wr_n   (bus_wr_n),
      .bus_dout   (bus_dout),
      .bus_doe    (bus_doe),
      .rsp_rdata  (rsp_rdata),
      .rsp_done   (rsp_done),
      .busy       (busy)
   );

   // behavioural reference: phase 0 idle, 1 T1, 2 T2, 3 wait, 4 T3
   int       m_ph = 0;
   bit [7:0] m_addr = 0, m_wdata = 0, m_rdata = 0;
   bit       m_wr = 0, m_done = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_addr = 0; m_wdata = 0; m_rdata = 0; m_wr = 0; m_done = 0;
      end else begin
         m_done = (m_ph == 4);
         if (m_ph == 4 && !m_wr) m_rdata = bus_din;
         case (m_ph)
            0: if (req_start) begin
                  m_ph = 1; m_addr = req_port; m_wdata = req_wdata; m_wr = req_write;
               end
            1: m_ph = 2;
            2: m_ph = 3;
            3: if (bus_wait_n) m_ph = 4;
            default: m_ph = 0;
         endcase
      end
   end

   task automatic chk(input string req, input string what, input int got, input int exp);
      tests++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && running) begin
         bit act, stb;
         act = (m_ph != 0);
         stb = (m_ph >= 2);
         chk("R2", "busy", busy, act);
         chk("R3", "addr", bus_addr, act ? m_addr : 0);
         chk("R4", "iorq_n", bus_iorq_n, !stb);
         chk("R4", "rd_n", bus_rd_n, !(stb && !m_wr));
         chk("R4", "wr_n", bus_wr_n, !(stb && m_wr));
         chk("R8", "doe", bus_doe, act && m_wr);
         chk("R8", "dout", bus_dout, (act && m_wr) ? m_wdata : 0);
         chk("R7", "rdata", rsp_rdata, m_rdata);
         chk("R9", "done", rsp_done, m_done);
         if (!bus_iorq_n) low_run++;
         if (rsp_done) begin
            last_low = low_run;
            low_run = 0;
         end
      end
   end

   // one transfer; returns at the negedge of the done cycle
   task automatic run_io(input bit wr, input bit [7:0] a, input bit [7:0] d,
                         input bit [7:0] din, input int extra, input bit wait_early,
                         input bit poke, input bit b2b);
      if (!b2b) @(negedge clk);
      req_start = 1'b1; req_write = wr; req_port = a; req_wdata = d;
      @(negedge clk);                       // T1
      req_start = 1'b0;
      bus_wait_n = !wait_early;
      @(negedge clk);                       // T2
      if (poke) begin
         req_start = 1'b1; req_port = ~a; req_wdata = ~d; req_write = !wr;
      end
      @(negedge clk);                       // first wait state
      req_start = 1'b0;
      if (poke) chk("R10", "addr after start while busy", bus_addr, a);
      for (int k = 0; k < extra; k++) begin
         bus_wait_n = 1'b0;
         @(negedge clk);
      end
      bus_wait_n = 1'b1;
      @(negedge clk);                       // T3
      bus_din = din;
      bus_wait_n = !wait_early;
      @(negedge clk);                       // done cycle
      bus_wait_n = 1'b1;
      #1;
      chk(extra == 0 ? "R5" : "R6", "strobe length", last_low, 3 + extra);
      if (!wr) chk("R7", "read result", rsp_rdata, din);
      chk("R9", "done seen", rsp_done, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      bit [7:0] held;
      repeat (3) @(negedge clk);
      chk("R1", "busy in reset", busy, 0);
      chk("R1", "iorq_n in reset", bus_iorq_n, 1);
      chk("R1", "rd_n in reset", bus_rd_n, 1);
      chk("R1", "wr_n in reset", bus_wr_n, 1);
      chk("R1", "addr in reset", bus_addr, 0);
      chk("R1", "doe in reset", bus_doe, 0);
      chk("R1", "rdata in reset", rsp_rdata, 0);
      chk("R1", "done in reset", rsp_done, 0);
      rst_n = 1'b1;
      running = 1'b1;
      @(negedge clk);
      chk("R1", "busy after reset", busy, 0);

      run_io(1'b0, 8'h84, 8'h00, 8'hF8, 0, 1'b0, 1'b0, 1'b0);
      run_io(1'b1, 8'h07, 8'h97, 8'h11, 0, 1'b0, 1'b0, 1'b0);
      chk("R7", "write keeps read result", rsp_rdata, 8'hF8);
      run_io(1'b0, 8'h3C, 8'h00, 8'h5A, 2, 1'b0, 1'b0, 1'b0);
      run_io(1'b1, 8'h9E, 8'h61, 8'h22, 0, 1'b1, 1'b0, 1'b0);
      run_io(1'b0, 8'h42, 8'h00, 8'h0F, 1, 1'b1, 1'b0, 1'b0);
      run_io(1'b0, 8'h55, 8'h00, 8'hC7, 0, 1'b0, 1'b1, 1'b0);
      // R10: start raised in the done cycle is taken at once
      run_io(1'b0, 8'hA5, 8'h00, 8'h3E, 0, 1'b0, 1'b0, 1'b0);
      held = rsp_rdata;
      req_start = 1'b1; req_write = 1'b1; req_port = 8'hC3; req_wdata = 8'h7D;
      @(negedge clk);
      req_start = 1'b0;
      chk("R10", "busy after start in done cycle", busy, 1);
      chk("R10", "addr after start in done cycle", bus_addr, 8'hC3);
      repeat (4) @(negedge clk);
      chk("R10", "done of chained write", rsp_done, 1);
      chk("R7", "rdata through chained write", rsp_rdata, held);
      for (int i = 0; i < 20; i++) begin
         run_io(i[0], 8'(i * 37 + 5), 8'(i * 91 + 3), 8'(i * 53 + 17),
                i % 3, i[2], i[1] & i[3], i[1]);
      end
      repeat (3) @(negedge clk);
      running = 1'b0;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule